// File: doc/BRIEF.md
# Configurable Logic Cell with Four-Input Lookup Table

The block is a single programmable logic cell. It computes one output bit from a 16-entry truth table. The four address bits of that table come from a small crossbar. Each crossbar leg picks one of the four cell input pins, the cell's own registered state, or a constant zero. A mode bit chooses how the result leaves the cell. It either goes straight from the table to the output, or it passes through a flip-flop on the functional clock.

All configuration is held in a 29-bit serial chain clocked by its own scan clock. Software loads the chain one bit per scan clock edge. Loading a second image pushes the old one out of the serial output, so a loader can compare it against what it wrote. The functional clock and its synchronous active-high reset touch only the output flip-flop, never the configuration.

Top module: `logic_cell`

## Requirements
- R1: The chain has 29 positions. On each scan_clk rising edge with scan_en high, every position k moves to k+1, scan_in enters position 0, and scan_out always shows position 28. After 29 shifts that present image element 28 first and element 0 last, position k holds element k.
- R2: Position 0 is the mode bit. Positions 1+3f to 3+3f hold select field f (f = 0..3), with the least significant bit at the lower position. Positions 13+a hold truth-table entry a (a = 0..15).
- R3: While scan_en is low, the configuration and scan_out do not change, whatever scan_in does.
- R4: While a second image is shifted in, scan_out presents the previously held image, element 28 first down to element 0, one element per shift.
- R5: Select codes 0 to 3 route cell_in[0] to cell_in[3] onto the corresponding address bit.
- R6: Select code 4 routes the cell's registered state onto the address bit.
- R7: Select codes 5, 6 and 7 force the address bit to 0.
- R8: Select field 0 drives the least significant address bit and field 3 drives the most significant. The result is the truth-table entry at that address.
- R9: With the mode bit at 1, cell_out follows the table result in the same cycle.
- R10: With the mode bit at 0, cell_out is the table result captured at the previous clk rising edge.
- R11: rst high at a clk rising edge clears the registered state to 0. This takes priority over capturing a table result of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock for the output flip-flop |
| rst | input | 1 | Synchronous active-high reset of the output flip-flop |
| scan_clk | input | 1 | Configuration chain clock |
| scan_en | input | 1 | Shift enable for the configuration chain |
| scan_in | input | 1 | Serial configuration input |
| scan_out | output | 1 | Serial configuration output (chain position 28) |
| cell_in | input | 4 | Cell input pins |
| cell_out | output | 1 | Cell result, combinational or registered |

## Verification
The feedback configuration turns the cell into a toggling flip-flop. This lets a reset arrive in the same clk edge where the flip-flop would otherwise capture a 1. The bench asserts rst exactly while the stored state is 0 and the table result is 1. It then expects 0 on the next two samples, while a cell that let the capture win would show 1. A second overlap occurs during reloads: scan_out is judged against the old image in each cycle that the new image is being shifted in.

// File: rtl/clb_cfg_pkg.sv
`timescale 1ns/1ps
package clb_cfg_pkg;
    parameter int unsigned K      = 4;   // table address width
    parameter int unsigned N_PINS = 4;   // cell input pins
    parameter int unsigned SEL_W  = 3;   // select field width

    localparam int unsigned LUT_BITS = 1 << K;
    localparam int unsigned CFG_W    = 1 + K * SEL_W + LUT_BITS;
    localparam int unsigned PIN_W    = $clog2(N_PINS);

    localparam logic [SEL_W-1:0] SEL_PIN_LIMIT = SEL_W'(N_PINS);
    localparam logic [SEL_W-1:0] SEL_FB        = SEL_W'(N_PINS);
    localparam logic [SEL_W-1:0] SEL_ZERO      = SEL_W'(N_PINS + 1);

    // packed MSB first: truth at top, mode bit at position 0
    typedef struct packed {
        logic [LUT_BITS-1:0]          truth;
        logic [K-1:0][SEL_W-1:0]      sel;
        logic                         comb_mode;
    } cfg_t;
endpackage

// File: rtl/cfg_scan_chain.sv
`timescale 1ns/1ps
module cfg_scan_chain
    import clb_cfg_pkg::*;
(
    input  logic scan_clk,
    input  logic rst,
    input  logic scan_en,
    input  logic scan_in,
    output cfg_t cfg,
    output logic scan_out
);
    typedef struct packed {
        logic [CFG_W-1:0] bits;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (scan_en) begin
            chain_d.bits = {chain_q.bits[CFG_W-2:0], scan_in};
        end
    end

    always_ff @(posedge scan_clk) begin
        chain_q <= chain_d;
    end

    assign cfg      = cfg_t'(chain_q.bits);
    assign scan_out = chain_q.bits[CFG_W-1];

    // R3: idle chain keeps its contents
    assert_chain_hold_R3: assert property (@(posedge scan_clk) disable iff (rst)
        !scan_en |=> $stable(chain_q.bits));

    // R1: serial bit lands at position 0 and the rest move up by one
    assert_chain_shift_R1: assert property (@(posedge scan_clk) disable iff (rst)
        scan_en |=> (chain_q.bits[0] == $past(scan_in)) &&
                    (chain_q.bits[CFG_W-1:1] == $past(chain_q.bits[CFG_W-2:0])));
endmodule

// File: rtl/lut_input_xbar.sv
`timescale 1ns/1ps
module lut_input_xbar
    import clb_cfg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_PINS-1:0]        pins,
    input  logic                     fb,
    input  logic [K-1:0][SEL_W-1:0]  sel,
    output logic [K-1:0]             addr
);
    for (genvar f = 0; f < K; f++) begin : g_leg
        logic leg_bit;

        always_comb begin
            leg_bit = 1'b0;
            if (sel[f] < SEL_PIN_LIMIT) begin
                leg_bit = pins[sel[f][PIN_W-1:0]];
            end else if (sel[f] == SEL_FB) begin
                leg_bit = fb;
            end
        end

        assign addr[f] = leg_bit;

        // R7: codes at or above the zero code give 0
        assert_zero_code_R7: assert property (@(posedge clk) disable iff (rst)
            (sel[f] >= SEL_ZERO) |-> !addr[f]);
    end
endmodule

// File: rtl/lut_read.sv
`timescale 1ns/1ps
module lut_read
    import clb_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [LUT_BITS-1:0] truth,
    input  logic [K-1:0]        addr,
    output logic                result
);
    always_comb begin
        result = truth[addr];
    end

    // R2: an all-zero table can never produce a 1
    assert_zero_table_R2: assert property (@(posedge clk) disable iff (rst)
        (truth == '0) |-> !result);
endmodule

// File: rtl/logic_cell.sv
`timescale 1ns/1ps
module logic_cell
    import clb_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_clk,
    input  logic              scan_en,
    input  logic              scan_in,
    output logic              scan_out,
    input  logic [N_PINS-1:0] cell_in,
    output logic              cell_out
);
    typedef struct packed {
        logic held;
    } state_t;

    cfg_t        cfg;
    logic [K-1:0] addr;
    logic        lut_q;
    state_t      st_d, st_q;

    cfg_scan_chain u_chain (
        .scan_clk (scan_clk),
        .rst      (rst),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .cfg      (cfg),
        .scan_out (scan_out)
    );

    lut_input_xbar u_xbar (
        .clk  (clk),
        .rst  (rst),
        .pins (cell_in),
        .fb   (st_q.held),
        .sel  (cfg.sel),
        .addr (addr)
    );

    lut_read u_lut (
        .clk    (clk),
        .rst    (rst),
        .truth  (cfg.truth),
        .addr   (addr),
        .result (lut_q)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.held = 1'b0;
        end else begin
            st_d.held = lut_q;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cell_out = cfg.comb_mode ? lut_q : st_q.held;

    // R11: first cycle out of reset sees a cleared state
    assert_reset_clear_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !st_q.held);

    // R10: state captures the table result of the previous cycle
    assert_capture_R10: assert property (@(posedge clk) disable iff (rst)
        !rst |=> st_q.held == $past(lut_q));

    // R9: combinational mode passes the table result through
    assert_comb_path_R9: assert property (@(posedge clk) disable iff (rst)
        cfg.comb_mode |-> cell_out == lut_q);
endmodule

// File: tb/sim_logic_cell.sv
`timescale 1ns/1ps
module sim_logic_cell;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_en = 1'b0;
    logic       scan_in = 1'b0;
    logic [3:0] cell_in = 4'h0;
    logic       scan_out;
    logic       cell_out;

    always #5 clk = ~clk;

    logic_cell u0 (
        .clk      (clk),
        .rst      (rst),
        .scan_clk (clk),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .scan_out (scan_out),
        .cell_in  (cell_in),
        .cell_out (cell_out)
    );

    typedef struct {
        int    due;
        string req;
        bit    on_scan;
        bit    exp;
    } item_t;

    item_t sb[$];
    int    ncnt  = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    logic  act_v;
    item_t cur;

    task automatic expect_at(int lag, string req, bit on_scan, bit exp);
        item_t it;
        it.due = ncnt + lag; it.req = req; it.on_scan = on_scan; it.exp = exp;
        sb.push_back(it);
    endtask

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        ncnt = ncnt + 1;
        while (sb.size() > 0 && sb[0].due <= ncnt) begin
            cur   = sb.pop_front();
            act_v = cur.on_scan ? scan_out : cell_out;
            n_cmp = n_cmp + 1;
            if (cur.due < ncnt || act_v !== cur.exp) begin
                n_bad = n_bad + 1;
                $display("FAIL %s: %s got %b expected %b (sample %0d)", cur.req,
                         cur.on_scan ? "scan_out" : "cell_out", act_v, cur.exp, ncnt);
            end
        end
    end

    function automatic logic [28:0] mk(bit mode, int s0, int s1, int s2, int s3,
                                       logic [15:0] t);
        logic [28:0] c;
        c[0]     = mode;
        c[3:1]   = 3'(s0);
        c[6:4]   = 3'(s1);
        c[9:7]   = 3'(s2);
        c[12:10] = 3'(s3);
        c[28:13] = t;
        return c;
    endfunction

    function automatic bit model(logic [28:0] c, logic [3:0] p, bit fb);
        int a = 0;
        for (int f = 0; f < 4; f++) begin
            logic [2:0] s = c[1+3*f +: 3];
            bit b;
            if (s < 3'd4)       b = p[s[1:0]];
            else if (s == 3'd4) b = fb;
            else                b = 1'b0;
            if (b) a = a | (1 << f);
        end
        return c[13+a];
    endfunction

    task automatic load(logic [28:0] c, bit rb, logic [28:0] prev);
        for (int k = 28; k >= 0; k--) begin
            @(posedge clk); #1;
            scan_en = 1'b1;
            scan_in = c[k];
            if (rb) expect_at(1, "R4", 1'b1, prev[k]);
        end
        @(posedge clk); #1;
        scan_en = 1'b0;
        expect_at(1, "R1", 1'b1, c[28]);
    endtask

    task automatic comb(logic [28:0] c, logic [3:0] p, string req);
        @(posedge clk); #1;
        cell_in = p;
        expect_at(1, req, 1'b0, model(c, p, 1'b0));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        logic [28:0] ca, cb, cc, cd, ce, cf;
        logic [9:0]  seq;
        bit          mq;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        expect_at(1, "R11", 1'b0, 1'b0);

        ca = mk(1'b1, 0, 1, 2, 3, 16'h6996);
        load(ca, 1'b0, '0);
        for (int i = 0; i < 16; i++) comb(ca, 4'(i), (i < 8) ? "R5" : "R9");

        cb = mk(1'b1, 3, 2, 1, 0, 16'hF0CA);
        load(cb, 1'b1, ca);
        for (int i = 0; i < 16; i++) comb(cb, 4'(i * 7 + 1), "R8");

        cc = mk(1'b1, 0, 1, 2, 3, 16'hF0CA);
        load(cc, 1'b1, cb);
        for (int i = 0; i < 16; i++) comb(cc, 4'(i), "R2");

        cd = mk(1'b1, 0, 5, 6, 7, 16'hFFFE);
        load(cd, 1'b1, cc);
        for (int i = 0; i < 16; i++) comb(cd, 4'(i), "R7");

        // R3: scan_in wiggles with the enable low
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            scan_in = ~scan_in;
            cell_in = 4'(i * 5);
            expect_at(1, "R3", 1'b0, model(cd, 4'(i * 5), 1'b0));
            expect_at(1, "R3", 1'b1, cd[28]);
        end

        ce = mk(1'b0, 0, 5, 5, 5, 16'h0002);
        load(ce, 1'b1, cd);
        seq = 10'b0110100111;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            cell_in = {3'b000, seq[i]};
            expect_at(2, "R10", 1'b0, seq[i]);
        end

        cf = mk(1'b0, 4, 5, 5, 5, 16'h0001);
        load(cf, 1'b1, ce);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        mq = 1'b0;
        expect_at(1, "R11", 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            mq = ~mq;
            expect_at(1, "R6", 1'b0, mq);
        end
        // state becomes 0 here, so the next capture would be 1
        @(posedge clk); #1;
        mq = ~mq;
        expect_at(1, "R6", 1'b0, mq);
        rst = 1'b1;
        expect_at(2, "R11", 1'b0, 1'b0);
        @(posedge clk); #1;
        rst = 1'b0;
        expect_at(1, "R11", 1'b0, 1'b0);
        @(posedge clk); #1;
        expect_at(1, "R6", 1'b0, 1'b1);

        repeat (4) @(posedge clk);
        if (sb.size() > 0) begin
            n_bad = n_bad + sb.size();
            $display("FAIL drain: got %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule